// File: doc/BRIEF.md
# Banked Register File with Write-Port Arbitration

This block holds a processor core's general registers as eight independent banks of sixteen 32-bit words. The banks form four sections, and each section has a left bank and a right bank. Registers at the same row in the two banks of one section form a pair, and a 64-bit value fills both halves of that pair. Every bank has one write port and three read ports. One read port belongs to the load/store path. The other two serve the A and B operand lines. Those two lines are wired straight from the source fields of the instruction that is being read.

Writes come from one load/store port and from several result-buffer queues. Each queue shows its head entry together with an age tag. Only one write can land in a bank per cycle, so each bank has its own arbiter. The load/store write always wins. After that, the oldest result-buffer entry wins. A queue pops its head only in a cycle where it sees its grant; a request that is refused is simply presented again. For every register pair the block also keeps valid flags: a data-valid bit and a UID-valid bit for each half, plus one location-known bit. A query port reads these flags out.

The design has no state machine. The only sequential state is the register contents and the pair flags, and the arbitration is purely combinational.

Top module: `banked_regfile`

## Requirements
- R1: A register address has 7 bits, {section[6:5], row[4:1], side[0]}. Side 1 (odd address) selects the left bank and side 0 the right bank. The bank index is section*2+side. A 32-bit write stores data[31:0] at that row of that bank.
- R2: A wide write ignores the side bit. It stores data[63:32] in the left bank and data[31:0] in the right bank of the addressed pair. A wide operand read returns {left, right}.
- R3: A valid load/store write is always performed. Any result-buffer request that targets a bank the load/store write uses in the same cycle is not granted.
- R4: Among result-buffer requests for one bank, the oldest wins. Tag a is older than tag b when bit AGE_W-1 of (a-b) mod 2^AGE_W is set, so the tags wrap. When tags are equal, the lower queue index wins.
- R5: A grant means the request is written at the next clock edge. A request that is not granted writes nothing. A wide request is granted only if it wins both banks; otherwise neither half is written.
- R6: Each bank takes at most one write per cycle. Requests that do not collide are all granted in the same cycle, up to eight writes.
- R7: Each bank's load/store read port returns the word at its 4-bit row without a clock. During the cycle in which that word is being written it returns the old value, and after the edge it returns the new one.
- R8: A 32-bit operand taken from an odd address comes from the left bank and one taken from an even address comes from the right bank. In both cases the word goes into bits [31:0] of the operand and bits [63:32] are zero.
- R9: When op_imm_a is set, operand A is the immediate (zero-extended for 32-bit, sign-extended to 64 bits for wide) and operand B is read using source field 0. Otherwise A uses source 0 and B uses source 1.
- R10: The flag query returns {location_known, uid_valid_left, uid_valid_right, data_valid_left, data_valid_right} in bits 4 down to 0. After reset every flag and every register is zero.
- R11: A data write sets data-valid and clears UID-valid for the half it writes. A load/store UID write sets UID-valid and clears data-valid for that half. Result-buffer writes are always data writes.
- R12: A load/store UID write with ls_wr_known set sets the pair's location-known bit. Any other write into that pair clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ls_wr_vld | input | 1 | Load/store write request |
| ls_wr_addr | input | 7 | Load/store write address |
| ls_wr_wide | input | 1 | Load/store write is 64-bit |
| ls_wr_uid | input | 1 | Load/store write carries a UID half, not data |
| ls_wr_known | input | 1 | Mark the pair's location as known (UID writes only) |
| ls_wr_data | input | 64 | Load/store write data |
| rb_wr_vld | input | NRB | Result-buffer head valid, one per queue |
| rb_wr_addr | input | NRB*7 | Result-buffer target addresses |
| rb_wr_wide | input | NRB | Result-buffer write is 64-bit |
| rb_wr_data | input | NRB*64 | Result-buffer write data |
| rb_wr_age | input | NRB*AGE_W | Result-buffer age tags |
| rb_wr_gnt | output | NRB | Grant; the queue pops its head |
| ls_rd_row | input | 8*4 | Row for each bank's load/store read port |
| ls_rd_data | output | 8*32 | Data from each bank's load/store read port |
| op_src0 | input | 7 | Instruction source field 0 |
| op_src1 | input | 7 | Instruction source field 1 |
| op_imm_a | input | 1 | Operand A is the immediate |
| op_wide | input | 1 | Operands are 64-bit |
| op_imm | input | 32 | Immediate value |
| op_a | output | 64 | Operand A |
| op_b | output | 64 | Operand B |
| flg_pair | input | 6 | Pair index {section,row} for the flag query |
| flg_out | output | 5 | Flags of the queried pair |

## Verification
Two functions can meet in the same cycle. First, a load/store write and result-buffer writes can aim at the same bank, while several queues with wrapping age tags compete there as well. Second, a read can address a word in the very cycle that word is being written. The bench sets up each collision on purpose: load/store against result buffer, oldest against younger across the wrap of the tag, and a wide request that loses one half. It also mixes them at random. On every clock a behavioural model checks the grants, the read data and the flags. A read taken in the writing cycle is expected to show the old value.

// File: rtl/rf_pkg.sv
package rf_pkg;

    // Flag record of one register pair; field order fixes the query encoding.
    typedef struct packed {
        logic lk;
        logic uv_l;
        logic uv_r;
        logic dv_l;
        logic dv_r;
    } pair_flags_t;

    // True when tag a is strictly older than tag b under wrapping arithmetic.
    function automatic logic age_older(input logic [15:0] a, input logic [15:0] b,
                                       input int unsigned w);
        logic [15:0] d;
        d = a - b;
        return d[w-1];
    endfunction

endpackage

// File: rtl/rf_bank_arb.sv
module rf_bank_arb #(
    parameter int NRB   = 4,
    parameter int AGE_W = 4
) (
    input  logic                 ls_hit,
    input  logic [NRB-1:0]       rb_hit,
    input  logic [NRB*AGE_W-1:0] rb_age,
    output logic                 win_ls,
    output logic [NRB-1:0]       win_rb
);
    import rf_pkg::*;

    always_comb begin
        logic             found;
        logic [AGE_W-1:0] best_age;
        win_rb   = '0;
        win_ls   = ls_hit;
        found    = 1'b0;
        best_age = '0;
        if (!ls_hit) begin
            for (int i = 0; i < NRB; i++) begin
                if (rb_hit[i] && (!found ||
                    age_older(16'(rb_age[i*AGE_W +: AGE_W]), 16'(best_age), AGE_W))) begin
                    found    = 1'b1;
                    best_age = rb_age[i*AGE_W +: AGE_W];
                    win_rb   = '0;
                    win_rb[i] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
    parameter int ROWS = 16,
    parameter int DW   = 32,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [ROW_W-1:0] wrow,
    input  logic [DW-1:0]    wdata,
    input  logic [ROW_W-1:0] ls_row,
    input  logic [ROW_W-1:0] a_row,
    input  logic [ROW_W-1:0] b_row,
    output logic [DW-1:0]    ls_rdata,
    output logic [DW-1:0]    a_rdata,
    output logic [DW-1:0]    b_rdata
);
    logic [DW-1:0] mem_q [ROWS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) mem_q[r] <= '0;
        end else if (we) begin
            mem_q[wrow] <= wdata;
        end
    end

    assign ls_rdata = mem_q[ls_row];
    assign a_rdata  = mem_q[a_row];
    assign b_rdata  = mem_q[b_row];

    logic             chk_we_q;
    logic [ROW_W-1:0] chk_row_q;
    logic [DW-1:0]    chk_data_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_we_q   <= 1'b0;
            chk_row_q  <= '0;
            chk_data_q <= '0;
        end else begin
            chk_we_q   <= we;
            chk_row_q  <= wrow;
            chk_data_q <= wdata;
        end
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        chk_we_q |-> mem_q[chk_row_q] == chk_data_q); // R7

endmodule

// File: rtl/rf_flags.sv
module rf_flags #(
    parameter int NSEC = 4,
    parameter int ROWS = 16,
    localparam int NBANK  = 2 * NSEC,
    localparam int ROW_W  = $clog2(ROWS),
    localparam int NPAIR  = NSEC * ROWS,
    localparam int PAIR_W = $clog2(NPAIR)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NBANK-1:0]       bank_we,
    input  logic [NBANK*ROW_W-1:0] bank_row,
    input  logic [NBANK-1:0]       bank_uid,
    input  logic                   lk_set,
    input  logic [PAIR_W-1:0]      lk_pair,
    input  logic [PAIR_W-1:0]      q_pair,
    output logic [4:0]             q_flags
);
    import rf_pkg::*;

    pair_flags_t flg_q [NPAIR];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NPAIR; p++) flg_q[p] <= '0;
        end else begin
            for (int p = 0; p < NPAIR; p++) begin
                logic touched;
                touched = 1'b0;
                for (int b = 0; b < NBANK; b++) begin
                    if (bank_we[b] && (b / 2) == (p / ROWS) &&
                        int'(bank_row[b*ROW_W +: ROW_W]) == (p % ROWS)) begin
                        touched = 1'b1;
                        if (b % 2 == 1) begin
                            flg_q[p].dv_l <= !bank_uid[b];
                            flg_q[p].uv_l <= bank_uid[b];
                        end else begin
                            flg_q[p].dv_r <= !bank_uid[b];
                            flg_q[p].uv_r <= bank_uid[b];
                        end
                    end
                end
                if (lk_set && int'(lk_pair) == p) flg_q[p].lk <= 1'b1;
                else if (touched)                 flg_q[p].lk <= 1'b0;
            end
        end
    end

    assign q_flags = flg_q[q_pair];

    for (genvar b = 0; b < NBANK; b++) begin : g_chk
        logic              cd_q;
        logic              cu_q;
        logic [PAIR_W-1:0] cp_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cd_q <= 1'b0;
                cu_q <= 1'b0;
                cp_q <= '0;
            end else begin
                cd_q <= bank_we[b] && !bank_uid[b];
                cu_q <= bank_we[b] && bank_uid[b];
                cp_q <= PAIR_W'((b / 2) * ROWS) + PAIR_W'(bank_row[b*ROW_W +: ROW_W]);
            end
        end
        if (b % 2 == 1) begin : g_l
            AST_DATA_SETS_DV: assert property (@(posedge clk) disable iff (!rst_n)
                cd_q |-> (flg_q[cp_q].dv_l && !flg_q[cp_q].uv_l)); // R11
            AST_UID_SETS_UV: assert property (@(posedge clk) disable iff (!rst_n)
                cu_q |-> (flg_q[cp_q].uv_l && !flg_q[cp_q].dv_l)); // R11
        end else begin : g_r
            AST_DATA_SETS_DV: assert property (@(posedge clk) disable iff (!rst_n)
                cd_q |-> (flg_q[cp_q].dv_r && !flg_q[cp_q].uv_r)); // R11
            AST_UID_SETS_UV: assert property (@(posedge clk) disable iff (!rst_n)
                cu_q |-> (flg_q[cp_q].uv_r && !flg_q[cp_q].dv_r)); // R11
        end
    end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile #(
    parameter int NSEC  = 4,
    parameter int ROWS  = 16,
    parameter int DW    = 32,
    parameter int NRB   = 4,
    parameter int AGE_W = 4,
    localparam int NBANK  = 2 * NSEC,
    localparam int SEC_W  = $clog2(NSEC),
    localparam int ROW_W  = $clog2(ROWS),
    localparam int ADDR_W = SEC_W + ROW_W + 1,
    localparam int PAIR_W = SEC_W + ROW_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ls_wr_vld,
    input  logic [ADDR_W-1:0]       ls_wr_addr,
    input  logic                    ls_wr_wide,
    input  logic                    ls_wr_uid,
    input  logic                    ls_wr_known,
    input  logic [2*DW-1:0]         ls_wr_data,
    input  logic [NRB-1:0]          rb_wr_vld,
    input  logic [NRB*ADDR_W-1:0]   rb_wr_addr,
    input  logic [NRB-1:0]          rb_wr_wide,
    input  logic [NRB*2*DW-1:0]     rb_wr_data,
    input  logic [NRB*AGE_W-1:0]    rb_wr_age,
    output logic [NRB-1:0]          rb_wr_gnt,
    input  logic [NBANK*ROW_W-1:0]  ls_rd_row,
    output logic [NBANK*DW-1:0]     ls_rd_data,
    input  logic [ADDR_W-1:0]       op_src0,
    input  logic [ADDR_W-1:0]       op_src1,
    input  logic                    op_imm_a,
    input  logic                    op_wide,
    input  logic [DW-1:0]           op_imm,
    output logic [2*DW-1:0]         op_a,
    output logic [2*DW-1:0]         op_b,
    input  logic [PAIR_W-1:0]       flg_pair,
    output logic [4:0]              flg_out
);
    logic [NBANK-1:0]       ls_hit;
    logic [NRB-1:0]         rb_hit [NBANK];
    logic [NBANK-1:0]       win_ls;
    logic [NRB-1:0]         win_rb [NBANK];
    logic [NBANK-1:0]       bank_we;
    logic [NBANK-1:0]       bank_uid;
    logic [NBANK*ROW_W-1:0] bank_row;
    logic [DW-1:0]          bank_wdata [NBANK];
    logic [DW-1:0]          a_rd [NBANK];
    logic [DW-1:0]          b_rd [NBANK];
    logic [ROW_W-1:0]       a_row, b_row;
    logic [ADDR_W-1:0]      b_src;

    assign b_src = op_imm_a ? op_src0 : op_src1;
    assign a_row = op_src0[ROW_W:1];
    assign b_row = b_src[ROW_W:1];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam logic [SEC_W-1:0] SEC_V = SEC_W'(b / 2);
        localparam logic             SIDE  = 1'(b % 2);

        assign ls_hit[b] = ls_wr_vld && ls_wr_addr[ADDR_W-1 -: SEC_W] == SEC_V &&
                           (ls_wr_wide || ls_wr_addr[0] == SIDE);
        for (genvar i = 0; i < NRB; i++) begin : g_hit
            assign rb_hit[b][i] = rb_wr_vld[i] &&
                rb_wr_addr[i*ADDR_W + ADDR_W-1 -: SEC_W] == SEC_V &&
                (rb_wr_wide[i] || rb_wr_addr[i*ADDR_W] == SIDE);
        end

        rf_bank_arb #(.NRB(NRB), .AGE_W(AGE_W)) u_arb (
            .ls_hit (ls_hit[b]),
            .rb_hit (rb_hit[b]),
            .rb_age (rb_wr_age),
            .win_ls (win_ls[b]),
            .win_rb (win_rb[b])
        );

        always_comb begin
            bank_we[b]  = win_ls[b];
            bank_uid[b] = win_ls[b] && ls_wr_uid;
            bank_row[b*ROW_W +: ROW_W] = ls_wr_addr[ROW_W:1];
            bank_wdata[b] = (ls_wr_wide && SIDE) ? ls_wr_data[2*DW-1:DW] : ls_wr_data[DW-1:0];
            for (int i = 0; i < NRB; i++) begin
                if (win_rb[b][i] && rb_wr_gnt[i]) begin
                    bank_we[b] = 1'b1;
                    bank_row[b*ROW_W +: ROW_W] = rb_wr_addr[i*ADDR_W+1 +: ROW_W];
                    bank_wdata[b] = (rb_wr_wide[i] && SIDE) ?
                        rb_wr_data[i*2*DW+DW +: DW] : rb_wr_data[i*2*DW +: DW];
                end
            end
        end

        rf_bank #(.ROWS(ROWS), .DW(DW)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .we       (bank_we[b]),
            .wrow     (bank_row[b*ROW_W +: ROW_W]),
            .wdata    (bank_wdata[b]),
            .ls_row   (ls_rd_row[b*ROW_W +: ROW_W]),
            .a_row    (a_row),
            .b_row    (b_row),
            .ls_rdata (ls_rd_data[b*DW +: DW]),
            .a_rdata  (a_rd[b]),
            .b_rdata  (b_rd[b])
        );

        AST_LS_BEATS_RB: assert property (@(posedge clk) disable iff (!rst_n)
            ls_hit[b] |-> (rb_hit[b] & rb_wr_gnt) == '0); // R3
        AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
            ($countones(rb_hit[b] & rb_wr_gnt) + 32'(ls_hit[b])) <= 1); // R6
    end

    // A request is granted only when it wins every bank it touches.
    always_comb begin
        for (int i = 0; i < NRB; i++) begin
            rb_wr_gnt[i] = rb_wr_vld[i];
            for (int b = 0; b < NBANK; b++) begin
                if (rb_hit[b][i] && !win_rb[b][i]) rb_wr_gnt[i] = 1'b0;
            end
        end
    end

    for (genvar i = 0; i < NRB; i++) begin : g_gchk
        AST_GNT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            rb_wr_gnt[i] |-> rb_wr_vld[i]); // R5
    end

    // Operand steering: source fields drive the bank read rows directly.
    always_comb begin
        int sa, sb;
        sa = int'(op_src0[ADDR_W-1 -: SEC_W]) * 2;
        sb = int'(b_src[ADDR_W-1 -: SEC_W]) * 2;
        if (op_imm_a)
            op_a = op_wide ? {{DW{op_imm[DW-1]}}, op_imm} : {{DW{1'b0}}, op_imm};
        else if (op_wide)
            op_a = {a_rd[sa+1], a_rd[sa]};
        else
            op_a = {{DW{1'b0}}, a_rd[sa + int'(op_src0[0])]};
        if (op_wide)
            op_b = {b_rd[sb+1], b_rd[sb]};
        else
            op_b = {{DW{1'b0}}, b_rd[sb + int'(b_src[0])]};
    end

    rf_flags #(.NSEC(NSEC), .ROWS(ROWS)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .bank_we  (bank_we),
        .bank_row (bank_row),
        .bank_uid (bank_uid),
        .lk_set   (ls_wr_vld && ls_wr_uid && ls_wr_known),
        .lk_pair  (ls_wr_addr[ADDR_W-1:1]),
        .q_pair   (flg_pair),
        .q_flags  (flg_out)
    );

endmodule

// File: tb/banked_regfile_bench.sv
module banked_regfile_bench;
    localparam int NRB = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic           ls_wr_vld, ls_wr_wide, ls_wr_uid, ls_wr_known;
    logic [6:0]     ls_wr_addr;
    logic [63:0]    ls_wr_data;
    logic [NRB-1:0] rb_wr_vld, rb_wr_wide, rb_wr_gnt;
    logic [NRB*7-1:0]  rb_wr_addr;
    logic [NRB*64-1:0] rb_wr_data;
    logic [NRB*4-1:0]  rb_wr_age;
    logic [31:0]    ls_rd_row;
    logic [255:0]   ls_rd_data;
    logic [6:0]     op_src0, op_src1;
    logic           op_imm_a, op_wide;
    logic [31:0]    op_imm;
    logic [63:0]    op_a, op_b;
    logic [5:0]     flg_pair;
    logic [4:0]     flg_out;

    banked_regfile u_banked_regfile (
        .clk(clk), .rst_n(rst_n),
        .ls_wr_vld(ls_wr_vld), .ls_wr_addr(ls_wr_addr), .ls_wr_wide(ls_wr_wide),
        .ls_wr_uid(ls_wr_uid), .ls_wr_known(ls_wr_known), .ls_wr_data(ls_wr_data),
        .rb_wr_vld(rb_wr_vld), .rb_wr_addr(rb_wr_addr), .rb_wr_wide(rb_wr_wide),
        .rb_wr_data(rb_wr_data), .rb_wr_age(rb_wr_age), .rb_wr_gnt(rb_wr_gnt),
        .ls_rd_row(ls_rd_row), .ls_rd_data(ls_rd_data),
        .op_src0(op_src0), .op_src1(op_src1), .op_imm_a(op_imm_a), .op_wide(op_wide),
        .op_imm(op_imm), .op_a(op_a), .op_b(op_b),
        .flg_pair(flg_pair), .flg_out(flg_out)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Behavioural reference state.
    logic [31:0] m_mem [8][16];
    logic [4:0]  m_flg [64];

    function automatic logic older(input logic [3:0] a, input logic [3:0] b);
        logic [3:0] d;
        d = a - b;
        return d[3];
    endfunction

    function automatic bit targets(input logic [6:0] adr, input logic wide, input int b);
        return (int'(adr[6:5]) == b / 2) && (wide || int'(adr[0]) == b % 2);
    endfunction

    function automatic logic [63:0] rd_op(input logic [6:0] adr, input logic wide);
        int s;
        s = int'(adr[6:5]) * 2;
        if (wide) return {m_mem[s+1][adr[4:1]], m_mem[s][adr[4:1]]};
        return {32'h0, m_mem[s + int'(adr[0])][adr[4:1]]};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        ls_wr_vld = 0; ls_wr_wide = 0; ls_wr_uid = 0; ls_wr_known = 0;
        ls_wr_addr = '0; ls_wr_data = '0;
        rb_wr_vld = '0; rb_wr_wide = '0; rb_wr_addr = '0; rb_wr_data = '0; rb_wr_age = '0;
    endtask

    task automatic set_rb(input int i, input logic [6:0] adr, input logic wide,
                          input logic [63:0] d, input logic [3:0] age);
        rb_wr_vld[i] = 1'b1;
        rb_wr_addr[i*7 +: 7] = adr;
        rb_wr_wide[i] = wide;
        rb_wr_data[i*64 +: 64] = d;
        rb_wr_age[i*4 +: 4] = age;
    endtask

    task automatic set_ls(input logic [6:0] adr, input logic wide, input logic uid,
                          input logic known, input logic [63:0] d);
        ls_wr_vld = 1; ls_wr_addr = adr; ls_wr_wide = wide;
        ls_wr_uid = uid; ls_wr_known = known; ls_wr_data = d;
    endtask

    // Compare all outputs against the model, then advance the model by one edge.
    task automatic step();
        int          win [8];
        logic [3:0]  ia;
        logic [NRB-1:0] eg;
        logic [63:0] ea, eb;
        bit          we [8];
        bit          wu [8];
        logic [3:0]  wr [8];
        logic [31:0] wd [8];
        bit          touched [64];
        #1;
        for (int b = 0; b < 8; b++) begin
            win[b] = -1;
            if (ls_wr_vld && targets(ls_wr_addr, ls_wr_wide, b)) win[b] = -2;
            else
                for (int i = 0; i < NRB; i++)
                    if (rb_wr_vld[i] && targets(rb_wr_addr[i*7 +: 7], rb_wr_wide[i], b))
                        if (win[b] == -1 || older(rb_wr_age[i*4 +: 4], ia)) begin
                            win[b] = i; ia = rb_wr_age[i*4 +: 4];
                        end
        end
        for (int i = 0; i < NRB; i++) begin
            eg[i] = rb_wr_vld[i];
            for (int b = 0; b < 8; b++)
                if (rb_wr_vld[i] && targets(rb_wr_addr[i*7 +: 7], rb_wr_wide[i], b) && win[b] != i)
                    eg[i] = 1'b0;
        end
        chk("R3 R4 R5 R6 grant", 64'(rb_wr_gnt), 64'(eg));
        for (int b = 0; b < 8; b++)
            chk("R7 R1 ls read", 64'(ls_rd_data[b*32 +: 32]), 64'(m_mem[b][ls_rd_row[b*4 +: 4]]));
        if (op_imm_a) ea = op_wide ? {{32{op_imm[31]}}, op_imm} : {32'h0, op_imm};
        else          ea = rd_op(op_src0, op_wide);
        eb = rd_op(op_imm_a ? op_src0 : op_src1, op_wide);
        chk("R8 R9 R2 operand A", op_a, ea);
        chk("R8 R9 R2 operand B", op_b, eb);
        chk("R10 R11 R12 flags", 64'(flg_out), 64'(m_flg[flg_pair]));
        for (int b = 0; b < 8; b++) begin
            we[b] = 0; wu[b] = 0; wr[b] = '0; wd[b] = '0;
            if (win[b] == -2) begin
                we[b] = 1; wu[b] = ls_wr_uid; wr[b] = ls_wr_addr[4:1];
                wd[b] = (ls_wr_wide && b % 2 == 1) ? ls_wr_data[63:32] : ls_wr_data[31:0];
            end else if (win[b] >= 0 && eg[win[b]]) begin
                we[b] = 1; wr[b] = rb_wr_addr[win[b]*7+1 +: 4];
                wd[b] = (rb_wr_wide[win[b]] && b % 2 == 1) ?
                        rb_wr_data[win[b]*64+32 +: 32] : rb_wr_data[win[b]*64 +: 32];
            end
        end
        @(posedge clk);
        #1;
        for (int p = 0; p < 64; p++) touched[p] = 0;
        for (int b = 0; b < 8; b++) if (we[b]) begin
            int p;
            p = (b / 2) * 16 + int'(wr[b]);
            m_mem[b][wr[b]] = wd[b];
            touched[p] = 1;
            if (b % 2 == 1) begin m_flg[p][1] = !wu[b]; m_flg[p][3] = wu[b]; end
            else            begin m_flg[p][0] = !wu[b]; m_flg[p][2] = wu[b]; end
        end
        for (int p = 0; p < 64; p++) if (touched[p]) m_flg[p][4] = 1'b0;
        if (ls_wr_vld && ls_wr_uid && ls_wr_known) m_flg[ls_wr_addr[6:1]][4] = 1'b1;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < 8; b++) for (int r = 0; r < 16; r++) m_mem[b][r] = '0;
        for (int p = 0; p < 64; p++) m_flg[p] = '0;
        idle();
        ls_rd_row = '0; op_src0 = '0; op_src1 = '0; op_imm_a = 0; op_wide = 0;
        op_imm = '0; flg_pair = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state is all zero.
        step();

        // R3: load/store and RB0 both aim at bank 1; RB0 loses.
        @(negedge clk); idle();
        set_ls(7'b00_0011_1, 0, 0, 0, 64'hA5A5_0001);
        set_rb(0, 7'b00_0101_1, 0, 64'h1111, 4'd0);
        ls_rd_row[1*4 +: 4] = 4'd3; op_src0 = 7'b00_0011_1; flg_pair = 6'd3;
        step();
        // RB0 retried alone and granted (R5); read shows the old value in that cycle (R7).
        @(negedge clk); idle();
        set_rb(0, 7'b00_0101_1, 0, 64'h1111, 4'd0);
        ls_rd_row[1*4 +: 4] = 4'd5;
        step();

        // R4: three queues on bank 3, ages 3,1,2: queue 1 wins.
        @(negedge clk); idle();
        set_rb(0, 7'b01_0010_1, 0, 64'hB0, 4'd3);
        set_rb(1, 7'b01_0100_1, 0, 64'hB1, 4'd1);
        set_rb(2, 7'b01_0110_1, 0, 64'hB2, 4'd2);
        step();
        // R4: wrap, age 15 is older than age 1.
        @(negedge clk); idle();
        set_rb(0, 7'b01_0010_1, 0, 64'hC0, 4'd15);
        set_rb(1, 7'b01_0100_1, 0, 64'hC1, 4'd1);
        step();
        // R4: equal ages, lower index wins.
        @(negedge clk); idle();
        set_rb(2, 7'b01_0110_1, 0, 64'hD2, 4'd6);
        set_rb(3, 7'b01_1000_1, 0, 64'hD3, 4'd6);
        step();

        // R5/R2: wide RB2 to section 2 loses its right half to load/store; nothing written.
        @(negedge clk); idle();
        set_ls(7'b10_0001_0, 0, 0, 0, 64'h77);
        set_rb(2, 7'b10_0111_0, 1, 64'hDEAD_BEEF_CAFE_F00D, 4'd0);
        op_src0 = 7'b10_0111_0; op_wide = 1; flg_pair = 6'b10_0111;
        step();
        @(negedge clk); idle();
        set_rb(2, 7'b10_0111_0, 1, 64'hDEAD_BEEF_CAFE_F00D, 4'd0);
        step();
        @(negedge clk); idle();
        step();

        // R6: five non-colliding writes in one cycle.
        @(negedge clk); idle();
        set_ls(7'b11_0000_0, 0, 0, 0, 64'h10);
        for (int i = 0; i < NRB; i++) set_rb(i, 7'(i * 32 + 1 + 2 * i), 0, 64'(32'h200 + i), 4'(i));
        step();

        // R8/R9: odd 32-bit operand, immediate A with B from source 0.
        @(negedge clk); idle();
        op_wide = 0; op_src0 = 7'b00_0011_1; op_src1 = 7'b00_0101_1; op_imm_a = 0;
        step();
        @(negedge clk);
        op_imm_a = 1; op_imm = 32'h8000_0001; op_src1 = 7'b11_0000_0;
        step();
        @(negedge clk);
        op_wide = 1; op_src0 = 7'b10_0111_0;
        step();
        op_imm_a = 0;

        // R12/R11: UID write marks known; a data write into the other half clears it.
        @(negedge clk); idle();
        set_ls(7'b01_1111_0, 1, 1, 1, 64'h0123_4567_89AB_CDEF);
        flg_pair = 6'b01_1111;
        step();
        @(negedge clk); idle();
        set_rb(1, 7'b01_1111_1, 0, 64'h55, 4'd0);
        step();
        @(negedge clk); idle();
        step();

        // Mixed random traffic.
        for (int n = 0; n < 600; n++) begin
            logic [3:0] base;
            @(negedge clk); idle();
            base = 4'(n);
            if ($urandom_range(0, 2) == 0)
                set_ls(7'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                       {$urandom, $urandom});
            for (int i = 0; i < NRB; i++)
                if ($urandom_range(0, 3) != 0)
                    set_rb(i, 7'($urandom), 1'($urandom_range(0, 3) == 0),
                           {$urandom, $urandom}, base + 4'($urandom_range(0, 7)));
            ls_rd_row = $urandom;
            op_src0 = 7'($urandom); op_src1 = 7'($urandom);
            op_imm_a = 1'($urandom); op_wide = 1'($urandom); op_imm = $urandom;
            flg_pair = 6'($urandom);
            step();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule